// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block caches virtual-to-physical page translations for a processor's memory path. Every stored translation carries the page number, the frame number, a writable flag and the identifier of the address space that owns it. A lookup searches all slots at once for the presented page number under the current address-space identifier. Because entries are tagged, translations from several processes can sit side by side across a context switch without a flush.

On a miss the block only reports the miss. The surrounding logic walks the page table and then presents the translation on the fill inputs. A fill may mark its entry as pinned. A pinned entry is never evicted to make room, and neither flush command removes it. Flushes can drop every unpinned entry, or only the unpinned entries of one address space.

Top module: `asid_tlb`

## Requirements
- R1: A lookup request (`lk_valid`=1) whose page number and identifier match a valid entry produces `res_valid`=1, `res_hit`=1 and that entry's frame and writable flag on the outputs one clock after the request. On a miss `res_hit`, `res_pfn` and `res_writable` are 0. `res_valid` is 0 in every cycle that does not follow a request.
- R2: An entry hits only when its stored identifier equals `lk_asid`. The same page number may be held under different identifiers at once, each returning its own frame.
- R3: After reset no entry is valid, every lookup misses and `res_valid` is 0.
- R4: A fill that matches no existing entry goes into the lowest-numbered invalid slot whenever one exists.
- R5: When every slot is valid, the fill replaces the slot chosen by a round-robin pointer. The pointer starts at slot 0 after reset. The choice is the first unpinned slot at or after the pointer, wrapping around. The pointer then moves to the slot just after the one replaced.
- R6: A fill whose page number and identifier equal those of a valid entry rewrites that entry in place. No other entry changes.
- R7: A lookup with `lk_write`=1 that hits an entry whose writable flag is 0 gives `res_fault`=1 together with `res_hit`=1. In every other case `res_fault` is 0.
- R8: `flush_all` invalidates every unpinned entry.
- R9: `flush_asid_en` invalidates every unpinned entry whose identifier equals `flush_asid`. Entries of other identifiers are left unchanged.
- R10: An entry filled with `fill_wired`=1 is never picked for replacement and survives both flush commands. A fill that finds every slot valid and pinned is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_write | input | 1 | Lookup is for a store |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number of the fill |
| fill_asid | input | ASID_W | Identifier of the fill |
| fill_pfn | input | PFN_W | Frame number of the fill |
| fill_writable | input | 1 | 1 = read-write page, 0 = read-only page |
| fill_wired | input | 1 | Pin the filled entry |
| flush_all | input | 1 | Invalidate all unpinned entries |
| flush_asid_en | input | 1 | Invalidate the unpinned entries of one identifier |
| flush_asid | input | ASID_W | Identifier selected for that flush |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Lookup found a translation |
| res_pfn | output | PFN_W | Translated frame number |
| res_writable | output | 1 | Writable flag of the hit entry |
| res_fault | output | 1 | Store to a read-only page |

## Verification
Each lookup result is due on the first clock edge after the request. The bench therefore drives a request on a falling edge and reads all five result outputs on the next falling edge, once that single register stage has loaded. A fill or flush applied on one falling edge has changed the table by the next rising edge, so any lookup issued afterwards already sees the new contents. Each full sweep over every page and identifier in the small configuration is compared against an expected translation set that the bench keeps from the requirements. Replacement order and pinning are confirmed by which translations disappear from one sweep to the next.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   // where a fill is written
   typedef enum logic [1:0] {
      FILL_NONE  = 2'd0,   // nowhere: every slot valid and pinned
      FILL_MATCH = 2'd1,   // rewrite the matching entry
      FILL_FREE  = 2'd2,   // lowest invalid slot
      FILL_RR    = 2'd3    // round-robin victim
   } fill_src_e;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic [ENTRIES-1:0]             valid_vec,
   input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_tab,
   input  logic [ENTRIES-1:0][ASID_W-1:0] asid_tab,
   input  logic [VPN_W-1:0]               key_vpn,
   input  logic [ASID_W-1:0]              key_asid,
   output logic [ENTRIES-1:0]             hit_vec
);

   initial begin
      assert (VPN_W >= 1 && ASID_W >= 1)
         else $error("tlb_cam: key widths must be positive");
   end

   // one comparator per slot, all evaluated in parallel
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = valid_vec[g]
                          && (vpn_tab[g] == key_vpn)
                          && (asid_tab[g] == key_asid);
   end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
   import tlb_pkg::*;
#(
   parameter int  ENTRIES = 16,
   localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill_valid,
   input  logic [ENTRIES-1:0] match_vec,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] wired_vec,
   output logic [IDX_W-1:0]   vic_idx,
   output fill_src_e          vic_src
);

   logic [IDX_W-1:0] rr_ptr;
   logic [IDX_W-1:0] match_idx, inv_idx, rr_idx;
   logic             match_any, inv_any, rr_any;
   int               slot;

   always_comb begin
      match_any = |match_vec;
      match_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match_vec[i]) match_idx = IDX_W'(i);
      end

      // descending scan leaves the lowest invalid slot
      inv_any = 1'b0;
      inv_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_vec[i]) begin
            inv_any = 1'b1;
            inv_idx = IDX_W'(i);
         end
      end

      // descending offsets leave the nearest unpinned slot from the pointer
      rr_any = 1'b0;
      rr_idx = '0;
      slot   = 0;
      for (int k = ENTRIES - 1; k >= 0; k--) begin
         slot = int'(rr_ptr) + k;
         if (slot >= ENTRIES) slot = slot - ENTRIES;
         if (!wired_vec[slot]) begin
            rr_any = 1'b1;
            rr_idx = IDX_W'(slot);
         end
      end

      if (match_any) begin
         vic_src = FILL_MATCH;
         vic_idx = match_idx;
      end else if (inv_any) begin
         vic_src = FILL_FREE;
         vic_idx = inv_idx;
      end else if (rr_any) begin
         vic_src = FILL_RR;
         vic_idx = rr_idx;
      end else begin
         vic_src = FILL_NONE;
         vic_idx = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_ptr <= '0;
      end else if (fill_valid && vic_src == FILL_RR) begin
         rr_ptr <= (rr_idx == IDX_W'(ENTRIES - 1)) ? '0 : rr_idx + 1'b1;
      end
   end

   AST_RR_SKIPS_WIRED: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_src == FILL_RR) |-> !wired_vec[vic_idx]);                  // R10
   AST_FREE_SLOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_src == FILL_FREE) |-> !valid_vec[vic_idx]);                // R4
   AST_RR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_src == FILL_RR) |-> (&valid_vec));                         // R5

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_write,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic              fill_writable,
   input  logic              fill_wired,
   input  logic              flush_all,
   input  logic              flush_asid_en,
   input  logic [ASID_W-1:0] flush_asid,
   output logic              res_valid,
   output logic              res_hit,
   output logic [PFN_W-1:0]  res_pfn,
   output logic              res_writable,
   output logic              res_fault
);

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   initial begin
      assert (ENTRIES >= 2) else $error("asid_tlb: ENTRIES must be at least 2");
      assert (PFN_W >= 1)   else $error("asid_tlb: PFN_W must be positive");
   end

   // entry storage
   logic [ENTRIES-1:0]             e_valid, e_wired, e_writ;
   logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
   logic [ENTRIES-1:0][ASID_W-1:0] e_asid;
   logic [ENTRIES-1:0][PFN_W-1:0]  e_pfn;

   logic [ENTRIES-1:0] lk_hit_vec, fl_hit_vec;
   logic [IDX_W-1:0]   vic_idx;
   fill_src_e          vic_src;
   logic               fill_do;
   logic [PFN_W-1:0]   rd_pfn;
   logic               rd_writ, rd_hit;

   tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_lookup (
      .valid_vec (e_valid),
      .vpn_tab   (e_vpn),
      .asid_tab  (e_asid),
      .key_vpn   (lk_vpn),
      .key_asid  (lk_asid),
      .hit_vec   (lk_hit_vec)
   );

   tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_fill (
      .valid_vec (e_valid),
      .vpn_tab   (e_vpn),
      .asid_tab  (e_asid),
      .key_vpn   (fill_vpn),
      .key_asid  (fill_asid),
      .hit_vec   (fl_hit_vec)
   );

   tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_valid (fill_valid),
      .match_vec  (fl_hit_vec),
      .valid_vec  (e_valid),
      .wired_vec  (e_wired),
      .vic_idx    (vic_idx),
      .vic_src    (vic_src)
   );

   assign fill_do = fill_valid && (vic_src != FILL_NONE);

   // one-hot OR mux of the hit entry
   always_comb begin
      rd_pfn  = '0;
      rd_writ = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_hit_vec[i]) begin
            rd_pfn  = rd_pfn | e_pfn[i];
            rd_writ = rd_writ | e_writ[i];
         end
      end
      rd_hit = |lk_hit_vec;
   end

   // per-slot update: fill writes its target, flushes clear unpinned slots
   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic tgt, drop;
      assign tgt  = fill_do && (vic_idx == IDX_W'(g));
      assign drop = !e_wired[g]
                    && (flush_all || (flush_asid_en && e_asid[g] == flush_asid));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            e_valid[g] <= 1'b0;
            e_wired[g] <= 1'b0;
            e_writ[g]  <= 1'b0;
            e_vpn[g]   <= '0;
            e_asid[g]  <= '0;
            e_pfn[g]   <= '0;
         end else if (tgt) begin
            e_valid[g] <= 1'b1;
            e_wired[g] <= fill_wired;
            e_writ[g]  <= fill_writable;
            e_vpn[g]   <= fill_vpn;
            e_asid[g]  <= fill_asid;
            e_pfn[g]   <= fill_pfn;
         end else if (drop) begin
            e_valid[g] <= 1'b0;
         end
      end

      AST_WIRED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
         (e_valid[g] && e_wired[g]) |=> e_valid[g]);                  // R10
   end

   // registered result, one cycle after the request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid    <= 1'b0;
         res_hit      <= 1'b0;
         res_pfn      <= '0;
         res_writable <= 1'b0;
         res_fault    <= 1'b0;
      end else begin
         res_valid    <= lk_valid;
         res_hit      <= lk_valid && rd_hit;
         res_pfn      <= (lk_valid && rd_hit) ? rd_pfn : '0;
         res_writable <= lk_valid && rd_hit && rd_writ;
         res_fault    <= lk_valid && rd_hit && lk_write && !rd_writ;
      end
   end

   AST_RES_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);                                        // R1
   AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid && !res_hit);                          // R1
   AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hit_vec));                                          // R6
   AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      res_fault |-> (res_hit && !res_writable));                      // R7
   AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      fill_do |=> (|e_valid));                                        // R4

endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N   = 4;
   localparam int VW  = 8;
   localparam int PW  = 8;
   localparam int AW  = 3;
   localparam int NV  = 32;   // page numbers swept
   localparam int NA  = 8;    // identifiers swept
   localparam int MS  = 8;    // expected-set capacity

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lk_valid = 0, lk_write = 0;
   logic [VW-1:0] lk_vpn = '0;
   logic [AW-1:0] lk_asid = '0;
   logic fill_valid = 0, fill_writable = 0, fill_wired = 0;
   logic [VW-1:0] fill_vpn = '0;
   logic [AW-1:0] fill_asid = '0;
   logic [PW-1:0] fill_pfn = '0;
   logic flush_all = 0, flush_asid_en = 0;
   logic [AW-1:0] flush_asid = '0;
   logic res_valid, res_hit, res_writable, res_fault;
   logic [PW-1:0] res_pfn;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // expected translation set
   bit m_on [MS];
   int m_vpn [MS];
   int m_asid [MS];
   int m_pfn [MS];
   bit m_wr [MS];

   always #(CLK_PERIOD / 2) clk = ~clk;

   asid_tlb #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) u_asid_tlb (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_write(lk_write),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
      .fill_pfn(fill_pfn), .fill_writable(fill_writable), .fill_wired(fill_wired),
      .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid),
      .res_valid(res_valid), .res_hit(res_hit), .res_pfn(res_pfn),
      .res_writable(res_writable), .res_fault(res_fault)
   );

   function automatic int pf(input int v, input int a);
      return (v * 7 + a * 13) % 256;
   endfunction

   task automatic m_put(input int v, input int a, input int p, input bit w);
      for (int i = 0; i < MS; i++) begin
         if (m_on[i] && m_vpn[i] == v && m_asid[i] == a) begin
            m_pfn[i] = p; m_wr[i] = w; return;
         end
      end
      for (int i = 0; i < MS; i++) begin
         if (!m_on[i]) begin
            m_on[i] = 1; m_vpn[i] = v; m_asid[i] = a; m_pfn[i] = p; m_wr[i] = w;
            return;
         end
      end
   endtask

   task automatic m_del(input int v, input int a);
      for (int i = 0; i < MS; i++)
         if (m_on[i] && m_vpn[i] == v && m_asid[i] == a) m_on[i] = 0;
   endtask

   task automatic check(input string tag, input bit ok, input string what,
                        input int got, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
      end
   endtask

   task automatic fill(input int v, input int a, input int p, input bit w, input bit wd);
      @(negedge clk);
      fill_valid = 1; fill_vpn = VW'(v); fill_asid = AW'(a);
      fill_pfn = PW'(p); fill_writable = w; fill_wired = wd;
      @(negedge clk);
      fill_valid = 0; fill_wired = 0;
   endtask

   task automatic flush(input bit all, input bit by_id, input int a);
      @(negedge clk);
      flush_all = all; flush_asid_en = by_id; flush_asid = AW'(a);
      @(negedge clk);
      flush_all = 0; flush_asid_en = 0;
   endtask

   // one lookup: request on a falling edge, result read on the next one
   task automatic lookup(input int v, input int a, input bit wr, input string tag);
      bit eh, ew, ef;
      int ep;
      eh = 0; ew = 0; ep = 0;
      for (int i = 0; i < MS; i++) begin
         if (m_on[i] && m_vpn[i] == v && m_asid[i] == a) begin
            eh = 1; ep = m_pfn[i]; ew = m_wr[i];
         end
      end
      ef = eh && wr && !ew;
      @(negedge clk);
      lk_valid = 1; lk_vpn = VW'(v); lk_asid = AW'(a); lk_write = wr;
      @(negedge clk);
      lk_valid = 0;
      total++;
      if (res_valid !== 1'b1 || res_hit !== eh || res_pfn !== PW'(ep)
          || res_writable !== ew || res_fault !== ef) begin
         bad++;
         $display("FAIL %s vpn=%0d asid=%0d got v/h/pfn/w/f=%0b/%0b/%0h/%0b/%0b exp=1/%0b/%0h/%0b/%0b",
                  tag, v, a, res_valid, res_hit, res_pfn, res_writable, res_fault,
                  eh, ep[PW-1:0], ew, ef);
      end
   endtask

   // every page and identifier; store lookups on odd (page+identifier) cover R7
   task automatic sweep(input string tag);
      for (int a = 0; a < NA; a++)
         for (int v = 0; v < NV; v++)
            lookup(v, a, ((v + a) % 2) == 1, tag);
   endtask

   initial begin
      for (int i = 0; i < MS; i++) m_on[i] = 0;
      repeat (3) @(negedge clk);
      check("R3", res_valid === 1'b0 && res_hit === 1'b0, "reset outputs",
            {res_valid, res_hit}, 0);
      rst_n = 1;
      @(negedge clk);
      sweep("R3 empty after reset");
      @(negedge clk);
      check("R1", res_valid === 1'b0, "res_valid idle", res_valid, 0);

      // R4: four fills go to slots 0..3; read-only on even pages
      for (int v = 1; v <= 4; v++) begin
         fill(v, 1, pf(v, 1), v % 2, 0);
         m_put(v, 1, pf(v, 1), v % 2);
      end
      sweep("R1 R2 R7 four entries");

      // R5: full table, pointer at 0 evicts page 1, then pointer 1 evicts page 2
      fill(5, 1, pf(5, 1), 1, 0); m_del(1, 1); m_put(5, 1, pf(5, 1), 1);
      fill(6, 1, pf(6, 1), 0, 0); m_del(2, 1); m_put(6, 1, pf(6, 1), 0);
      sweep("R5 round robin");

      // R6: rewrite of page 3 in place, nothing evicted
      fill(3, 1, 8'h77, 1, 0); m_put(3, 1, 8'h77, 1);
      sweep("R6 overwrite");

      // R8: flush everything unpinned
      flush(1, 0, 0);
      for (int i = 0; i < MS; i++) m_on[i] = 0;
      sweep("R8 flush all");

      // R10: two pinned entries in slots 0 and 1; pointer still at 2
      fill(10, 2, pf(10, 2), 1, 1); m_put(10, 2, pf(10, 2), 1);
      fill(11, 2, pf(11, 2), 0, 1); m_put(11, 2, pf(11, 2), 0);
      fill(12, 3, pf(12, 3), 1, 0); m_put(12, 3, pf(12, 3), 1);
      fill(13, 2, pf(13, 2), 1, 0); m_put(13, 2, pf(13, 2), 1);
      fill(14, 3, pf(14, 3), 0, 0); m_del(12, 3); m_put(14, 3, pf(14, 3), 0);
      fill(15, 3, pf(15, 3), 1, 0); m_del(13, 2); m_put(15, 3, pf(15, 3), 1);
      fill(16, 3, pf(16, 3), 1, 0); m_del(14, 3); m_put(16, 3, pf(16, 3), 1);
      sweep("R5 R10 pinned skipped by replacement");

      // R9: drop identifier 3 only
      flush(0, 1, 3); m_del(15, 3); m_del(16, 3);
      sweep("R9 flush by identifier");
      // R10: pinned identifier-2 entries survive both flush kinds
      flush(0, 1, 2);
      flush(1, 0, 0);
      sweep("R10 pinned survive flush");

      // R2 R4: same page under two identifiers in slots 2 and 3
      fill(20, 2, 8'h21, 1, 0); m_put(20, 2, 8'h21, 1);
      fill(20, 5, 8'h52, 0, 0); m_put(20, 5, 8'h52, 0);
      sweep("R2 same page two identifiers");
      flush(0, 1, 5); m_del(20, 5);
      sweep("R9 other identifier kept");

      // R10: fill pages 30,31 pinned so every slot is pinned; then a fill is discarded
      flush(0, 1, 2); m_del(20, 2);
      fill(30, 4, pf(30, 4), 1, 1); m_put(30, 4, pf(30, 4), 1);
      fill(31, 4, pf(31, 4), 1, 1); m_put(31, 4, pf(31, 4), 1);
      fill(29, 4, pf(29, 4), 1, 0);
      sweep("R10 fill discarded when all pinned");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule